// File: doc/BRIEF.md
# Log-Depth Zero Counter

This block counts the zero bits that come before the first set bit of an N-bit input vector. It counts either from the most significant end (leading zeros) or from the least significant end (trailing zeros). It is purely combinational. There is no clock, no reset and no state, so the count follows the input within the same cycle. Designers drop it into normalisation, arbitration or free-slot search paths where a linear priority chain would be too deep.

The count is produced by a balanced halving tree of 2:1 multiplexers and inverters. Every node carries an all-zero flag as its top bit. A width that is not a power of two is widened with zeros above the MSB, and the surplus is then subtracted from the tree result. A trailing-zero count reuses the same tree on the bit-reversed input. Three parameters fix the unit at build time:

- `N`, the input width, from 4 to 64;
- `DIR`, the counting direction (`ZC_LEADING` or `ZC_TRAILING`);
- `FMT`, the result format (`ZC_FULL` or `ZC_SHORT`).

The style has no state machine to name. The block has no states and no transitions.

Top module: `zero_count_unit`

## Requirements
- R1: With `DIR=ZC_LEADING` and `FMT=ZC_FULL`, `count` is `N` for an all-zero `din`; otherwise it is `N-1` minus the index of the highest set bit. `count` is `$clog2(N+1)` bits wide.
- R2: With `DIR=ZC_TRAILING` and `FMT=ZC_FULL`, `count` is `N` for an all-zero `din`; otherwise it is the index of the lowest set bit. The width is the same as in R1.
- R3: With `FMT=ZC_SHORT`, `count` is `$clog2(N)` bits wide. For every nonzero `din` it equals the full count of the selected direction, truncated from the top. For an all-zero `din` its value is unspecified.
- R4: Widths that are not powers of two (for example 5, 12 and 33) give exactly the counts of R1 to R3.
- R5: `count` depends only on the present `din`. A new input value is reflected within the same clock period, with no clock edge involved.
- R6: An all-ones `din` gives a count of 0 in both directions and both formats.
- R7: A `din` with only bit 0 and bit `N-1` set gives a count of 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | N | Vector whose leading or trailing zeros are counted |
| count | output | CNT_W (`$clog2(N+1)` full, `$clog2(N)` short) | Zero count |

## Verification
Every result is due zero cycles after its stimulus, because the unit holds no registers. The bench changes `din` just after a rising edge of its reference clock and compares `count` at the following falling edge, half a period later. No clock edge reaches the design between stimulus and sample. Instances of widths 4, 5, 12, 32, 33 and 64 in different direction and format settings are driven together with the same vector sets:

- the zero vector;
- every one-hot vector;
- every low-ones run;
- every run of cleared low bits;
- both alternating patterns;
- the two-ends vector.

The zero vector is not compared on short-format instances.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;

    typedef enum logic {
        ZC_LEADING  = 1'b0,
        ZC_TRAILING = 1'b1
    } zc_dir_e;

    typedef enum logic {
        ZC_FULL  = 1'b0,
        ZC_SHORT = 1'b1
    } zc_fmt_e;

    // Result width for a given input width and format.
    function automatic int count_width(input int n, input zc_fmt_e fmt);
        return (fmt == ZC_SHORT) ? $clog2(n) : $clog2(n + 1);
    endfunction

    // Smallest power of two not below n.
    function automatic int pow2_ceil(input int n);
        return 1 << $clog2(n);
    endfunction

endpackage

// File: rtl/zcnt_orient.sv
module zcnt_orient
    import zcnt_pkg::*;
#(
    parameter int      N   = 32,
    parameter zc_dir_e DIR = ZC_LEADING
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    generate
        if (DIR == ZC_TRAILING) begin : g_rev
            for (genvar i = 0; i < N; i++) begin : g_bit
                assign dout[i] = din[N-1-i];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate

    // R2: reordering keeps every set bit
    always_comb begin
        if (!$isunknown(din)) begin
            orient_ones_chk: assert ($countones(dout) == $countones(din))
                else $error("orient changed number of set bits");
        end
    end

endmodule

// File: rtl/zcnt_tree.sv
module zcnt_tree #(
    parameter int P = 32
) (
    input  logic [P-1:0]         vec,
    output logic [$clog2(P):0]   lz
);

    localparam int LP = $clog2(P);

    generate
        for (genvar l = 0; l <= LP; l++) begin : g_lvl
            logic [l:0] nd [0:(P>>l)-1];
            if (l == 0) begin : g_leaf
                for (genvar j = 0; j < P; j++) begin : g_n
                    assign nd[j] = ~vec[j];
                end
            end else if (l == 1) begin : g_first
                for (genvar j = 0; j < (P >> 1); j++) begin : g_n
                    assign nd[j] = g_lvl[0].nd[2*j+1][0]
                        ? {g_lvl[0].nd[2*j][0], ~g_lvl[0].nd[2*j][0]}
                        : {1'b0, g_lvl[0].nd[2*j+1][0]};
                end
            end else begin : g_upper
                for (genvar j = 0; j < (P >> l); j++) begin : g_n
                    logic [l-1:0] hi;
                    logic [l-1:0] lo;
                    assign hi = g_lvl[l-1].nd[2*j+1];
                    assign lo = g_lvl[l-1].nd[2*j];
                    assign nd[j] = hi[l-1]
                        ? {lo[l-1], ~lo[l-1], lo[l-2:0]}
                        : {1'b0, hi};
                end
            end
        end
    endgenerate

    assign lz = g_lvl[LP].nd[0];

    // R1: the top flag of the root marks an all-zero vector
    always_comb begin
        if (!$isunknown(vec)) begin
            root_flag_chk: assert (lz[LP] == (vec == '0))
                else $error("tree zero flag wrong");
        end
    end

endmodule

// File: rtl/zcnt_fit.sv
module zcnt_fit
    import zcnt_pkg::*;
#(
    parameter int      N   = 32,
    parameter zc_fmt_e FMT = ZC_FULL,
    localparam int     P     = pow2_ceil(N),
    localparam int     RAW_W = $clog2(P) + 1,
    localparam int     CNT_W = count_width(N, FMT)
) (
    input  logic [RAW_W-1:0] raw,
    output logic [CNT_W-1:0] count
);

    localparam int PAD = P - N;

    logic [RAW_W-1:0] adj;

    generate
        if (PAD == 0) begin : g_exact
            assign adj = raw;
        end else begin : g_trim
            assign adj = raw - RAW_W'(PAD);
        end
    endgenerate

    assign count = adj[CNT_W-1:0];

    // R4: padded zeros always lead, so the padded count covers them
    always_comb begin
        if (!$isunknown(raw)) begin
            pad_floor_chk: assert (int'(raw) >= PAD)
                else $error("padded count below pad amount");
            // R1
            full_range_chk: assert (int'(adj) <= N)
                else $error("count exceeds width");
        end
    end

endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
    import zcnt_pkg::*;
#(
    parameter int      N     = 32,
    parameter zc_dir_e DIR   = ZC_LEADING,
    parameter zc_fmt_e FMT   = ZC_FULL,
    localparam int     CNT_W = count_width(N, FMT)
) (
    input  logic [N-1:0]     din,
    output logic [CNT_W-1:0] count
);

    localparam int P     = pow2_ceil(N);
    localparam int RAW_W = $clog2(P) + 1;

    logic [N-1:0]     oriented;
    logic [P-1:0]     padded;
    logic [RAW_W-1:0] raw;

    zcnt_orient #(.N(N), .DIR(DIR)) u_orient (
        .din  (din),
        .dout (oriented)
    );

    generate
        if (P == N) begin : g_nopad
            assign padded = oriented;
        end else begin : g_pad
            assign padded = {{(P-N){1'b0}}, oriented};
        end
    endgenerate

    zcnt_tree #(.P(P)) u_tree (
        .vec (padded),
        .lz  (raw)
    );

    zcnt_fit #(.N(N), .FMT(FMT)) u_fit (
        .raw   (raw),
        .count (count)
    );

    // Port-level check of the found position.
    logic pos_ok;
    always_comb begin
        int c;
        c = int'(count);
        pos_ok = (c < N);
        for (int i = 0; i < N; i++) begin
            if (DIR == ZC_LEADING) begin
                if (i > N - 1 - c && din[i]) pos_ok = 1'b0;
                if (i == N - 1 - c && !din[i]) pos_ok = 1'b0;
            end else begin
                if (i < c && din[i]) pos_ok = 1'b0;
                if (i == c && !din[i]) pos_ok = 1'b0;
            end
        end
        if (!$isunknown(din) && din != '0) begin
            // R1 R2 R3: nonzero input points at its first set bit
            first_one_chk: assert (pos_ok)
                else $error("count does not point at first set bit");
        end
        if (!$isunknown(din) && din == '0 && FMT == ZC_FULL) begin
            // R1
            zero_full_chk: assert (int'(count) == N)
                else $error("zero input must give N");
        end
    end

endmodule

// File: tb/zero_count_unit_tb.sv
module zero_count_unit_tb;
    import zcnt_pkg::*;

    localparam int NI = 12;
    localparam int CFG_N [0:NI-1] = '{32, 32, 32, 32, 5, 5, 12, 12, 33, 33, 64, 4};
    localparam int CFG_T [0:NI-1] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
    localparam int CFG_S [0:NI-1] = '{0, 0, 1, 1, 0, 1, 0, 0, 1, 0, 0, 1};
    localparam int WIDTHS [0:5]   = '{4, 5, 12, 32, 33, 64};

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [63:0] vin  [0:NI-1];
    logic [6:0]  vout [0:NI-1];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [5:0] dut_cnt;
    zero_count_unit #(.N(32), .DIR(ZC_LEADING), .FMT(ZC_FULL)) u_dut (
        .din   (vin[0][31:0]),
        .count (dut_cnt)
    );
    assign vout[0] = 7'(dut_cnt);

    generate
        for (genvar g = 1; g < NI; g++) begin : g_inst
            localparam zc_fmt_e F = zc_fmt_e'(CFG_S[g]);
            logic [count_width(CFG_N[g], F)-1:0] o;
            zero_count_unit #(
                .N   (CFG_N[g]),
                .DIR (zc_dir_e'(CFG_T[g])),
                .FMT (F)
            ) u_inst (
                .din   (vin[g][CFG_N[g]-1:0]),
                .count (o)
            );
            assign vout[g] = 7'(o);
        end
    endgenerate

    function automatic int ref_cnt(logic [63:0] v, int n, int tr);
        if ((v & mask_of(n)) == 64'd0) return n;
        if (tr == 0) begin
            for (int i = n - 1; i >= 0; i--) if (v[i]) return n - 1 - i;
        end else begin
            for (int i = 0; i < n; i++) if (v[i]) return i;
        end
        return n;
    endfunction

    function automatic logic [63:0] mask_of(int n);
        return (n >= 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
    endfunction

    task automatic check_inst(int g, logic [63:0] v, string tag);
        int n;
        int exp;
        string req;
        n = CFG_N[g];
        if (CFG_S[g] != 0 && v == 64'd0) return;   // R3: zero is unspecified
        exp = ref_cnt(v, n, CFG_T[g]);
        req = (CFG_S[g] != 0) ? "R3" : ((CFG_T[g] != 0) ? "R2" : "R1");
        if ((n & (n - 1)) != 0) req = {req, "/R4"};
        checks++;
        if (int'(vout[g]) != exp) begin
            errors++;
            $display("FAIL %s/R5 %s N=%0d trailing=%0d short=%0d in=%h actual=%0d expected=%0d",
                     req, tag, n, CFG_T[g], CFG_S[g], v, vout[g], exp);
        end
    endtask

    // Drive after a rising edge, compare at the next falling edge (R5).
    task automatic apply(int width, logic [63:0] v, string tag);
        @(posedge clk);
        for (int g = 0; g < NI; g++) if (CFG_N[g] == width) vin[g] = v;
        @(negedge clk);
        for (int g = 0; g < NI; g++) if (CFG_N[g] == width) check_inst(g, v, tag);
    endtask

    task automatic t_zero(int n);
        apply(n, 64'd0, "R1 R2 zero");
    endtask

    task automatic t_onehot(int n);
        for (int k = 0; k < n; k++) apply(n, 64'd1 << k, "onehot");
    endtask

    task automatic t_low_ones(int n);
        for (int k = 1; k <= n; k++)
            apply(n, mask_of(k), (k == n) ? "R6 all ones" : "low ones");
    endtask

    task automatic t_low_cleared(int n);
        for (int k = 0; k < n; k++)
            apply(n, mask_of(n) & ~mask_of(k), (k == 0) ? "R6 all ones" : "low cleared");
    endtask

    task automatic t_alternating(int n);
        apply(n, 64'hAAAA_AAAA_AAAA_AAAA & mask_of(n), "alt 1010");
        apply(n, 64'h5555_5555_5555_5555 & mask_of(n), "alt 0101");
    endtask

    task automatic t_ends(int n);
        apply(n, 64'd1 | (64'd1 << (n - 1)), "R7 both ends");
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NI; g++) vin[g] = 64'd0;
        for (int w = 0; w < 6; w++) begin
            t_zero(WIDTHS[w]);
            t_onehot(WIDTHS[w]);
            t_low_ones(WIDTHS[w]);
            t_low_cleared(WIDTHS[w]);
            t_alternating(WIDTHS[w]);
            t_ends(WIDTHS[w]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule